// File: doc/BRIEF.md
# Aliased Sub-Word Register File

This block holds four 32-bit general data registers. Each register can be reached through three overlapping views: the whole 32-bit word, its low 16-bit half, and either byte of that half. Writes of any width touch only the lanes they target and keep every other bit of that register. Reads of any width are zero-extended to 32 bits.

Two read ports and one write port each take a 2-bit register index and a 2-bit size code. A write lands on the rising clock edge when the enable is high. Reads are combinational, and the value they return is the stored contents from before any write in the same cycle. A synchronous active-high reset clears all four registers.

Top module: `subword_regfile`

## Requirements
- R1: A synchronous active-high reset clears all four registers to zero, so every read that follows returns 0.
- R2: The size code is 2'b00 for the low byte (bits 7:0), 2'b01 for the high byte of the low half (bits 15:8), 2'b10 for the low half (bits 15:0) and 2'b11 for the full word (bits 31:0).
- R3: A full-word write with the enable high replaces all 32 bits of the indexed register at the rising clock edge.
- R4: A 16-bit write changes only bits 15:0 of the indexed register and keeps bits 31:16.
- R5: A low-byte write changes only bits 7:0, and a high-byte write changes only bits 15:8 taking its data from wdata bits 7:0. All other bits are kept.
- R6: A read returns the selected lanes moved down to bit 0 and zero-extended to 32 bits. A high-byte read returns bits 15:8 in bits 7:0.
- R7: With the enable low, no register changes, whatever the index, size and data inputs are.
- R8: A write changes only the register its index selects. The other three registers keep their contents.
- R9: Reads are combinational. A read of the register being written returns the old contents until the clock edge, with no bypass.
- R10: The two read ports work independently and can read the same register or different registers, at any sizes, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 2 | Register index for the write |
| wr_size | input | 2 | Size code for the write |
| wr_data | input | 32 | Write data, right-aligned |
| rd0_idx | input | 2 | Register index for read port 0 |
| rd0_size | input | 2 | Size code for read port 0 |
| rd0_data | output | 32 | Zero-extended data from read port 0 |
| rd1_idx | input | 2 | Register index for read port 1 |
| rd1_size | input | 2 | Size code for read port 1 |
| rd1_data | output | 32 | Zero-extended data from read port 1 |

## Verification
A faulty lane mask or merge damages bits that the write did not target. This shows up on the very next full-word read of that register, one clock edge after the write. A wrong lane shift or zero-extension shows up right away on a narrow read, in the same cycle, because the read path is combinational. A write that reaches the wrong register, or a hidden bypass, shows up on the other read port during the writing cycle or after the edge. The bench compares full-word readbacks of all four registers against a shadow model it keeps itself, so any stray change is caught within one cycle.

// File: rtl/subword_regfile_pkg.sv
package subword_regfile_pkg;

    localparam int WORD_W  = 32;
    localparam int NUM_REG = 4;
    localparam int IDX_W   = $clog2(NUM_REG);
    localparam int BYTE_W  = 8;
    localparam int HALF_W  = 16;

    typedef enum logic [1:0] {
        SZ_LO_BYTE = 2'b00,
        SZ_HI_BYTE = 2'b01,
        SZ_HALF    = 2'b10,
        SZ_WORD    = 2'b11
    } access_size_e;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  ridx_t;

    typedef struct packed {
        logic         en;
        ridx_t        idx;
        access_size_e size;
        word_t        data;
    } wr_req_t;

    // Bit mask of the lanes one access touches, in register position.
    function automatic word_t lane_mask(access_size_e sz);
        word_t m;
        case (sz)
            SZ_LO_BYTE: m = word_t'({BYTE_W{1'b1}});
            SZ_HI_BYTE: m = word_t'({BYTE_W{1'b1}}) << BYTE_W;
            SZ_HALF:    m = word_t'({HALF_W{1'b1}});
            default:    m = '1;
        endcase
        return m;
    endfunction

    // Bit offset of the lowest lane the access touches.
    function automatic int unsigned lane_shift(access_size_e sz);
        return (sz == SZ_HI_BYTE) ? BYTE_W : 0;
    endfunction

endpackage

// File: rtl/subword_write_merge.sv
module subword_write_merge
    import subword_regfile_pkg::*;
(
    input  word_t        cur,
    input  access_size_e size,
    input  word_t        wdata,
    output word_t        merged
);
    word_t mask;
    word_t aligned;

    always_comb begin
        mask    = lane_mask(size);
        aligned = wdata << lane_shift(size);
        merged  = (cur & ~mask) | (aligned & mask);
    end

    // R4 R5: bits outside the selected lanes come through unchanged
    always_comb begin
        a_r5_keep_lanes: assert ((merged & ~lane_mask(size)) == (cur & ~lane_mask(size)))
            else $error("merge altered untouched lanes");
    end
endmodule

// File: rtl/subword_read_align.sv
module subword_read_align
    import subword_regfile_pkg::*;
(
    input  word_t        word,
    input  access_size_e size,
    output word_t        rdata
);
    always_comb begin
        rdata = (word & lane_mask(size)) >> lane_shift(size);
    end

    // R6: narrow reads are zero-extended
    always_comb begin
        a_r6_zero_ext: assert ((size == SZ_WORD) || (rdata[WORD_W-1:HALF_W] == '0))
            else $error("narrow read not zero-extended");
    end
endmodule

// File: rtl/subword_regfile.sv
module subword_regfile
    import subword_regfile_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_idx,
    input  logic [1:0]  wr_size,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd0_idx,
    input  logic [1:0]  rd0_size,
    output logic [31:0] rd0_data,
    input  logic [1:0]  rd1_idx,
    input  logic [1:0]  rd1_size,
    output logic [31:0] rd1_data
);
    localparam int NUM_RD = 2;

    word_t   regs [NUM_REG];
    word_t   merged;
    wr_req_t wreq;

    assign wreq = '{en: wr_en, idx: wr_idx, size: access_size_e'(wr_size), data: wr_data};

    subword_write_merge u_merge (
        .cur    (regs[wreq.idx]),
        .size   (wreq.size),
        .wdata  (wreq.data),
        .merged (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REG; i++) regs[i] <= '0;
        end else if (wreq.en) begin
            regs[wreq.idx] <= merged;
        end
    end

    ridx_t        rd_idx  [NUM_RD];
    access_size_e rd_size [NUM_RD];
    word_t        rd_out  [NUM_RD];

    assign rd_idx[0]  = rd0_idx;
    assign rd_idx[1]  = rd1_idx;
    assign rd_size[0] = access_size_e'(rd0_size);
    assign rd_size[1] = access_size_e'(rd1_size);

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        subword_read_align u_align (
            .word  (regs[rd_idx[p]]),
            .size  (rd_size[p]),
            .rdata (rd_out[p])
        );
    end

    assign rd0_data = rd_out[0];
    assign rd1_data = rd_out[1];

    // R1: the cycle after a reset, every register is zero
    for (genvar r = 0; r < NUM_REG; r++) begin : g_chk
        a_r1_reset_clear: assert property (@(posedge clk)
            rst |=> (regs[r] == '0))
            else $error("reset did not clear register");
        // R7 R8: a register that was not written holds its value
        a_r8_untouched_hold: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_idx == r) |=> $stable(regs[r]))
            else $error("unwritten register changed");
    end

    // R3: a full-word write stores the data exactly
    a_r3_full_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == SZ_WORD) |=> (regs[$past(wr_idx)] == $past(wr_data)))
        else $error("full write mismatch");
endmodule

// File: tb/subword_regfile_test.sv
module subword_regfile_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    logic        clk = 0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_idx, wr_size, rd0_idx, rd0_size, rd1_idx, rd1_size;
    logic [31:0] wr_data;
    logic [31:0] rd0_data, rd1_data;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    subword_regfile uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
        .wr_data(wr_data), .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data)
    );

    // vector: {idx, size, data}
    localparam logic [35:0] VEC [NVEC] = '{
        {2'd0, 2'b11, 32'hDEADBEEF},
        {2'd1, 2'b11, 32'h12345678},
        {2'd2, 2'b11, 32'hFFFFFFFF},
        {2'd3, 2'b11, 32'hA5A5A5A5},
        {2'd0, 2'b00, 32'h00000011},
        {2'd0, 2'b01, 32'hFFFFFF22},
        {2'd1, 2'b10, 32'hAAAA9876},
        {2'd2, 2'b00, 32'h00000000},
        {2'd2, 2'b01, 32'h00000000},
        {2'd3, 2'b10, 32'h0000C3C3},
        {2'd3, 2'b01, 32'h0000007E},
        {2'd1, 2'b00, 32'hFFFFFFAB}
    };

    function automatic logic [31:0] mdl_merge(logic [31:0] cur, logic [1:0] sz, logic [31:0] d);
        case (sz)
            2'b00: return {cur[31:8], d[7:0]};
            2'b01: return {cur[31:16], d[7:0], cur[7:0]};
            2'b10: return {cur[31:16], d[15:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] mdl_read(logic [31:0] w, logic [1:0] sz);
        case (sz)
            2'b00: return {24'd0, w[7:0]};
            2'b01: return {24'd0, w[15:8]};
            2'b10: return {16'd0, w[15:0]};
            default: return w;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compares all four registers in full-word view against the model.
    task automatic check_all(string req);
        for (int r = 0; r < 4; r++) begin
            rd0_idx = 2'(r); rd0_size = 2'b11;
            #1;
            check(req, rd0_data, model[r]);
        end
    endtask

    task automatic do_write(logic [1:0] idx, logic [1:0] sz, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = idx; wr_size = sz; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        model[idx] = mdl_merge(model[idx], sz, d);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1; wr_en = 0; wr_idx = 0; wr_size = 0; wr_data = 0;
        rd0_idx = 0; rd0_size = 3; rd1_idx = 0; rd1_size = 3;
        for (int r = 0; r < 4; r++) model[r] = 32'd0;
        repeat (2) @(negedge clk);
        rst = 0;
        check_all("R1 reset clear");

        // vector walk: R3 full, R4 half, R5 bytes, R8 isolation
        for (int v = 0; v < NVEC; v++) begin
            do_write(VEC[v][35:34], VEC[v][33:32], VEC[v][31:0]);
            check_all("R3/R4/R5/R8 vector");
        end

        // R6: narrow read views of register 0 (now 0xDEAD2211)
        for (int s = 0; s < 4; s++) begin
            rd0_idx = 2'd0; rd0_size = 2'(s);
            rd1_idx = 2'd3; rd1_size = 2'(3 - s);
            #1;
            check("R6 read view p0", rd0_data, mdl_read(model[0], 2'(s)));
            check("R10 read view p1", rd1_data, mdl_read(model[3], 2'(3 - s)));
        end

        // R7: enable low with active-looking inputs changes nothing
        @(negedge clk);
        wr_en = 0; wr_idx = 2'd2; wr_size = 2'b11; wr_data = 32'h0BADF00D;
        @(negedge clk); @(negedge clk);
        check_all("R7 disabled write");

        // R9: same-cycle read returns old value, new after the edge
        @(negedge clk);
        wr_en = 1; wr_idx = 2'd1; wr_size = 2'b11; wr_data = 32'h55AA55AA;
        rd1_idx = 2'd1; rd1_size = 2'b11;
        #1;
        check("R9 no bypass", rd1_data, model[1]);
        @(negedge clk);
        wr_en = 0;
        model[1] = 32'h55AA55AA;
        #1;
        check("R9 after edge", rd1_data, 32'h55AA55AA);

        // R10: both ports read the same register at different sizes
        rd0_idx = 2'd1; rd0_size = 2'b01; rd1_idx = 2'd1; rd1_size = 2'b10;
        #1;
        check("R10 same reg p0", rd0_data, 32'h00000055);
        check("R10 same reg p1", rd1_data, 32'h000055AA);

        // R2 R5: a high-byte write uses wdata[7:0] only
        do_write(2'd2, 2'b01, 32'hC3C3C300);
        check_all("R5 high byte source");

        // R1: reset after data clears everything
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        for (int r = 0; r < 4; r++) model[r] = 32'd0;
        check_all("R1 reset after data");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule